// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a 16-bit up-counter reached over an 8-bit byte bus with a two-bit address. It counts either an internal instruction-rate tick (a one-cycle pulse supplied from outside, typically once every four system clocks) or rising edges seen on an external clock pin. A power-of-two prescaler sits between the chosen source and the counter. A run bit gates counting. A synchronizer-enable bit decides whether the external pin passes through extra synchronizing flops before edge detection. A rollover raises a sticky interrupt flag. A clear input, driven by a compare unit's match trigger, zeroes the counter.

Software can reach the counter in two ways. In byte mode, the high byte is read and written directly. In wide mode, the high byte goes through a holding buffer: a read of the low byte snapshots the live high byte, and a write of the low byte loads both halves at once. This keeps 16-bit accesses coherent while the counter runs.

Address map: 0 = count low byte, 1 = count high byte (or buffer), 2 = control, 3 = status. Control bits: [0] run, [1] external source, [2] synchronizer enable, [4:3] prescale select, [7] wide mode, [6:5] read as zero. Status bit 0 is the overflow flag.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the count, the control register and the status register all read 0, and irq_o is low.
- R2: With control bits run=1, external source=0 and prescale=0, each clock edge that samples tick_i high advances the count by one at that same edge. Edges on ext_clk_i have no effect in this mode.
- R3: With run=0, the count holds its value whatever tick_i or ext_clk_i do.
- R4: Prescale select k (control bits [4:3]) passes every 2^k-th source pulse to the counter. The prescaler restarts from zero whenever address 0 or address 1 is written. A control write does not restart it.
- R5: With external source=1, the count advances once per rising edge of ext_clk_i, and tick_i is ignored. With the synchronizer off, the increment lands on the second clock edge after the rising input is first sampled high. With the synchronizer on, it lands on the fourth such edge (SYNC_STAGES=2).
- R6: In internal-source mode the synchronizer-enable bit has no effect: a tick still increments the count on the edge that samples it.
- R7: A rollover from 0xFFFF to 0x0000 sets status bit 0 and irq_o. The flag stays set through later counting until software writes 0 to status bit 0.
- R8: trig_clr_i high at a clock edge sets the count to 0 at that edge. It wins over a simultaneous increment and over a simultaneous count-byte write.
- R9: In byte mode (control bit 7 = 0), address 1 reads and writes the live high byte and address 0 the low byte. Address 2 reads back the control value with bits [6:5] as 0.
- R10: In wide mode, a read of address 0 copies the live high byte into the buffer. Address 1 reads return the buffer. Address 1 writes change only the buffer. A write of address 0 loads the count with {buffer, written byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-rate tick, one-cycle pulse |
| ext_clk_i | input | 1 | External count input |
| trig_clr_i | input | 1 | Compare-match trigger that clears the count |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (side effect in wide mode) |
| bus_rdata_o | output | DATA_W | Read data, combinational on address |
| irq_o | output | 1 | Overflow interrupt flag |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2, which gives a 16-bit count and a three-stage external path. At this width, rollover is reached by loading 0xFFFE and sending two ticks, rather than by a long wait. With two synchronizer stages, the exact edge on which a synchronized external edge lands can be checked against the unsynchronized one. A prescale field of two bits keeps the largest ratio at eight, so a restart of the prescaler by a byte write shows up within a handful of ticks.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int unsigned ADDR_W = 2;
  localparam int unsigned PSEL_W = 2;
  localparam int unsigned PS_W   = (1 << PSEL_W) - 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              wide;
    logic [1:0]        spare;
    logic [PSEL_W-1:0] psel;
    logic              sync_en;
    logic              ext_sel;
    logic              run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // low-bit mask a prescaler count must fill for ratio 2^sel
  function automatic logic [PS_W-1:0] presc_mask(input logic [PSEL_W-1:0] sel);
    return PS_W'((32'd1 << sel) - 32'd1);
  endfunction

  function automatic logic presc_hit(input logic [PS_W-1:0] cnt,
                                     input logic [PSEL_W-1:0] sel);
    return (cnt & presc_mask(sel)) == presc_mask(sel);
  endfunction

  function automatic ctrl_t ctrl_from_bus(input logic [CTRL_W-1:0] d);
    ctrl_t c;
    c       = ctrl_t'(d);
    c.spare = '0;
    return c;
  endfunction

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic sync_en_i,
  output logic rise_o
);

  logic                   raw_q;
  logic                   raw_prev_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   rise_raw;
  logic                   rise_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q       <= 1'b0;
      raw_prev_q  <= 1'b0;
      sync_prev_q <= 1'b0;
    end else begin
      raw_q       <= raw_i;
      raw_prev_q  <= raw_q;
      sync_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= raw_q;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_q};
      end
    end
  endgenerate

  assign rise_raw  = raw_q & ~raw_prev_q;
  assign rise_sync = sync_q[SYNC_STAGES-1] & ~sync_prev_q;
  assign rise_o    = sync_en_i ? rise_sync : rise_raw;

  // R5: one input edge yields a single-cycle pulse on each path
  assert_rise_raw_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_raw |=> !rise_raw);
  assert_rise_sync_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_sync |=> !rise_sync);

endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);

  logic [PS_W-1:0] pcnt_q;
  logic            take;

  assign take   = src_i & en_i;
  assign tick_o = take & presc_hit(pcnt_q, sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (clr_i) pcnt_q <= '0;
    else if (take)  pcnt_q <= pcnt_q + 1'b1;
  end

  // R4: with a ratio above one, two back-to-back passes cannot happen
  assert_presc_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_i != '0 && !clr_i) |=> (!tick_o || sel_i != $past(sel_i)));

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc_i,
  input  logic                clr_i,
  input  logic                wide_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic                rd_lo_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                flag_wr_i,
  input  logic                flag_wdata_i,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0]   hbuf_o,
  output logic                flag_o,
  output logic                ovf_o
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  function automatic logic [CNT_W:0] step(input logic [CNT_W-1:0] c);
    return {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hbuf_q;
  logic              flag_q;
  logic [CNT_W:0]    stepped;
  logic              load_lo;
  logic              load_hi;
  logic              bumped;

  assign stepped = step(cnt_q);
  assign load_lo = wr_lo_i;
  assign load_hi = wr_hi_i & ~wide_i;
  assign bumped  = inc_i & ~clr_i & ~load_lo & ~load_hi;
  assign ovf_o   = bumped & stepped[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (load_lo) cnt_q <= wide_i ? {hbuf_q, wdata_i} : {cnt_q[CNT_W-1:DATA_W], wdata_i};
    else if (load_hi) cnt_q <= {wdata_i, cnt_q[DATA_W-1:0]};
    else if (inc_i)   cnt_q <= stepped[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hbuf_q <= '0;
    else if (rd_lo_i && wide_i) hbuf_q <= cnt_q[CNT_W-1:DATA_W];
    else if (wr_hi_i)           hbuf_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (ovf_o)     flag_q <= 1'b1;
    else if (flag_wr_i) flag_q <= flag_wdata_i;
  end

  assign cnt_o  = cnt_q;
  assign hbuf_o = hbuf_q;
  assign flag_o = flag_q;

  // R8: the trigger always leaves a zero count behind
  assert_trig_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);
  // R2: an uncontested increment moves the count by exactly one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && !wr_lo_i && !wr_hi_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R3: without increment, clear or write the count is frozen
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  // R7: rollover raises the flag, and it stays up until software writes it
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> flag_q);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_wr_i) |=> flag_q);
  // R10: a low-byte read in wide mode snapshots the live high byte
  assert_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo_i && wide_i) |=> hbuf_q == $past(cnt_q[CNT_W-1:DATA_W]));

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ext_clk_i,
  input  logic              trig_clr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  ctrl_t             ctrl_q;
  reg_sel_e          sel;
  logic              wr_lo;
  logic              wr_hi;
  logic              wr_ctrl;
  logic              wr_stat;
  logic              rd_lo;
  logic              ext_rise;
  logic              src_pulse;
  logic              presc_clr;
  logic              cnt_inc;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hbuf;
  logic              flag;
  logic              ovf;

  assign sel     = reg_sel_e'(bus_addr_i);
  assign wr_lo   = bus_wr_i && sel == REG_CNT_LO;
  assign wr_hi   = bus_wr_i && sel == REG_CNT_HI;
  assign wr_ctrl = bus_wr_i && sel == REG_CTRL;
  assign wr_stat = bus_wr_i && sel == REG_STAT;
  assign rd_lo   = bus_rd_i && sel == REG_CNT_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_from_bus(bus_wdata_i[CTRL_W-1:0]);
  end

  tmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (ext_clk_i),
    .sync_en_i (ctrl_q.sync_en),
    .rise_o    (ext_rise)
  );

  assign src_pulse = ctrl_q.ext_sel ? ext_rise : tick_i;
  assign presc_clr = wr_lo | wr_hi;

  tmr16_prescale u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_pulse),
    .en_i   (ctrl_q.run),
    .clr_i  (presc_clr),
    .sel_i  (ctrl_q.psel),
    .tick_o (cnt_inc)
  );

  tmr16_count #(.DATA_W(DATA_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .inc_i        (cnt_inc),
    .clr_i        (trig_clr_i),
    .wide_i       (ctrl_q.wide),
    .wr_lo_i      (wr_lo),
    .wr_hi_i      (wr_hi),
    .rd_lo_i      (rd_lo),
    .wdata_i      (bus_wdata_i),
    .flag_wr_i    (wr_stat),
    .flag_wdata_i (bus_wdata_i[0]),
    .cnt_o        (cnt),
    .hbuf_o       (hbuf),
    .flag_o       (flag),
    .ovf_o        (ovf)
  );

  always_comb begin
    unique case (sel)
      REG_CNT_LO: bus_rdata_o = cnt[DATA_W-1:0];
      REG_CNT_HI: bus_rdata_o = ctrl_q.wide ? hbuf : cnt[CNT_W-1:DATA_W];
      REG_CTRL:   bus_rdata_o = DATA_W'(ctrl_q);
      REG_STAT:   bus_rdata_o = DATA_W'(flag);
      default:    bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag;

  // R3: a stopped timer never hands an increment to the counter
  assert_run_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !cnt_inc);
  // R7: a rollover shows up on irq_o at the following edge
  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq_o);
  // R5: in external mode a counter increment needs a detected pin edge
  assert_ext_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ext_sel && cnt_inc) |-> ext_rise);

endmodule

// File: tb/tb_tmr16_unit.sv
`timescale 1ns/100ps
module tb_tmr16_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       trig_clr_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  mon_ev;

  always #2.5 clk = ~clk;

  tmr16_unit #(.DATA_W(8), .SYNC_STAGES(2)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .ext_clk_i   (ext_clk_i),
    .trig_clr_i  (trig_clr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  // monitor: pops each expected read and compares it with the bus
  always begin
    @(mon_ev);
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (bus_rdata_o !== it.exp) begin
        errors++;
        $display("FAIL %s: read 0x%02h expected 0x%02h", it.tag, bus_rdata_o, it.exp);
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk); #1;
    bus_wr_i = 1'b0;
  endtask

  task automatic write_trig(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1; trig_clr_i = 1'b1;
    @(posedge clk); #1;
    bus_wr_i = 1'b0; trig_clr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    @(posedge clk); #1;
    bus_rd_i = 1'b0;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(posedge clk); #1; tick_i = 1'b0;
    end
  endtask

  task automatic trig_tick(input logic with_tick);
    @(negedge clk); trig_clr_i = 1'b1; tick_i = with_tick;
    @(posedge clk); #1; trig_clr_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ext(input logic v);
    @(negedge clk); ext_clk_i = v;
  endtask

  task automatic ext_pulse();
    set_ext(1'b1); idle(2);
    set_ext(1'b0); idle(2);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); #1;
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: irq_o %0b expected %0b", tag, irq_o, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(2'd0, 8'h00, "R1 count low after reset");
    bus_read(2'd1, 8'h00, "R1 count high after reset");
    bus_read(2'd2, 8'h00, "R1 control after reset");
    bus_read(2'd3, 8'h00, "R1 status after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R9: control readback masks the spare bits
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, 8'h9F, "R9 control readback");

    // R2: internal ticks, ext pin ignored
    bus_write(2'd2, 8'h01);
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h00);
    pulse_tick(5);
    bus_read(2'd0, 8'h05, "R2 five ticks");
    ext_pulse(); idle(5);
    bus_read(2'd0, 8'h05, "R2 ext pin ignored in timer mode");

    // R3: stopped timer holds
    bus_write(2'd2, 8'h00);
    pulse_tick(3);
    bus_read(2'd0, 8'h05, "R3 hold while stopped");

    // R4: prescale ratios and restart on byte write
    bus_write(2'd2, 8'h11);
    bus_write(2'd0, 8'h00);
    pulse_tick(10);
    bus_read(2'd0, 8'h02, "R4 ratio 4 over ten ticks");
    bus_write(2'd2, 8'h19);
    bus_write(2'd0, 8'h00);
    pulse_tick(7);
    bus_read(2'd0, 8'h00, "R4 ratio 8 after seven ticks");
    pulse_tick(1);
    bus_read(2'd0, 8'h01, "R4 ratio 8 after eight ticks");
    bus_write(2'd2, 8'h11);
    bus_write(2'd0, 8'h00);
    pulse_tick(3);
    bus_write(2'd0, 8'h40);
    pulse_tick(3);
    bus_read(2'd0, 8'h40, "R4 prescaler restarted by write");
    pulse_tick(1);
    bus_read(2'd0, 8'h41, "R4 fourth tick after restart");

    // R5: unsynchronized external edge latency, tick ignored
    bus_write(2'd2, 8'h03);
    bus_write(2'd0, 8'h00);
    set_ext(1'b1);
    bus_read(2'd0, 8'h00, "R5 unsync one edge after");
    bus_read(2'd0, 8'h01, "R5 unsync two edges after");
    set_ext(1'b0); idle(2);
    pulse_tick(3);
    bus_read(2'd0, 8'h01, "R5 tick ignored in counter mode");

    // R5: synchronized external edge latency and counting
    bus_write(2'd2, 8'h07);
    set_ext(1'b1);
    bus_read(2'd0, 8'h01, "R5 sync one edge after");
    bus_read(2'd0, 8'h01, "R5 sync two edges after");
    bus_read(2'd0, 8'h01, "R5 sync three edges after");
    bus_read(2'd0, 8'h02, "R5 sync four edges after");
    set_ext(1'b0); idle(4);
    ext_pulse(); ext_pulse(); ext_pulse();
    idle(5);
    bus_read(2'd0, 8'h05, "R5 three synchronized edges");

    // R6: sync bit has no effect in timer mode
    bus_write(2'd2, 8'h05);
    bus_write(2'd0, 8'h00);
    pulse_tick(1);
    bus_read(2'd0, 8'h01, "R6 tick lands same edge with sync bit set");

    // R7: overflow flag
    bus_write(2'd2, 8'h01);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd0, 8'hFE);
    bus_read(2'd3, 8'h00, "R7 flag clear before rollover");
    pulse_tick(1);
    bus_read(2'd0, 8'hFF, "R7 count at top");
    bus_read(2'd3, 8'h00, "R7 flag clear at top");
    chk_irq(1'b0, "R7 irq low at top");
    pulse_tick(1);
    bus_read(2'd0, 8'h00, "R7 low wraps");
    bus_read(2'd1, 8'h00, "R7 high wraps");
    bus_read(2'd3, 8'h01, "R7 flag set by rollover");
    chk_irq(1'b1, "R7 irq high after rollover");
    pulse_tick(1);
    bus_read(2'd3, 8'h01, "R7 flag sticky");
    bus_write(2'd3, 8'h00);
    bus_read(2'd3, 8'h00, "R7 flag cleared by software");
    chk_irq(1'b0, "R7 irq low after clear");

    // R8: trigger clear and its priority
    bus_write(2'd1, 8'h12);
    bus_write(2'd0, 8'h34);
    trig_tick(1'b0);
    bus_read(2'd0, 8'h00, "R8 trigger clears low");
    bus_read(2'd1, 8'h00, "R8 trigger clears high");
    bus_write(2'd0, 8'h55);
    trig_tick(1'b1);
    bus_read(2'd0, 8'h00, "R8 trigger beats increment");
    write_trig(2'd0, 8'h77);
    bus_read(2'd0, 8'h00, "R8 trigger beats byte write");

    // R9: byte mode direct high access
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'h3C);
    bus_read(2'd1, 8'h3C, "R9 direct high write");
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, 8'h00, "R9 direct low write");

    // R10: wide mode buffered high byte
    bus_write(2'd2, 8'h80);
    bus_write(2'd1, 8'hAB);
    bus_read(2'd0, 8'h00, "R10 low read in wide mode");
    bus_read(2'd1, 8'h3C, "R10 high write reached only the buffer");
    bus_write(2'd1, 8'hAB);
    bus_write(2'd0, 8'hCD);
    bus_read(2'd0, 8'hCD, "R10 paired write low");
    bus_read(2'd1, 8'hAB, "R10 paired write high");
    bus_write(2'd2, 8'h81);
    bus_write(2'd1, 8'h12);
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, 8'hFF, "R10 coherent read low");
    pulse_tick(1);
    bus_read(2'd1, 8'h12, "R10 buffer keeps snapshot across carry");
    bus_write(2'd2, 8'h01);
    bus_read(2'd1, 8'h13, "R10 live high after carry");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule